// File: doc/BRIEF.md
# CPU Burst Clock Duty Controller

This block produces the clock-enable for a processor core. The clocks for the peripherals are not affected. Time is divided into repeating burst periods. Each period consists of a fixed number of equal slots, and each slot lasts a fixed number of system clock cycles. Software writes a control word that holds a gating enable bit and a 5-bit duty width. While gating is enabled, the core clock runs for the first `width` slots of every period and is held off for the rest. A width of zero holds the core off for the whole period, which is the doze state.

Any interrupt request clears the enable bit, and the core clock then runs continuously until software turns gating on again. Software can also end gating by writing the enable bit low. Every register write restarts the period at slot zero. The output therefore has a known phase relative to the write that configured it.

The slot length is an elaboration parameter. The integrator picks it so that one period lasts 1 ms at the chosen system clock. For example, 268 cycles per slot and 31 slots give a period of about 1 ms at 8.3 MHz.

Top module: `cpu_burst_gate`

## Requirements
- R1: After reset the enable bit is clear, the width is 31 (the slot count) and `cpu_clk_en` is high.
- R2: A cycle with `wr_en` high loads `wr_enable_bit` and `wr_width`, and the new gating applies from the next clock edge.
- R3: Each slot lasts `SLOT_CYCLES` clock cycles, a period holds `NUM_SLOTS` (31) slots, and periods repeat without a gap.
- R4: With gating enabled and width W in 1..30, `cpu_clk_en` is high for slots 0..W-1 of each period and low for slots W..30.
- R5: With gating enabled and width 0, `cpu_clk_en` stays low for as long as the setting holds (doze).
- R6: A width of 31 keeps `cpu_clk_en` high for the whole period.
- R7: An `irq` high at a clock edge clears the enable bit, and `cpu_clk_en` is high from that edge until the next write enables gating.
- R8: While the enable bit is clear, `cpu_clk_en` is high whatever the width.
- R9: A write restarts the period, so the edge after the write begins slot 0, cycle 0.
- R10: Apart from the edge after a write or an interrupt, `cpu_clk_en` changes only at slot boundaries.
- R11: If `irq` and `wr_en` are high in the same cycle, the width is taken from the write but the enable bit ends clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_enable_bit | input | 1 | Gating enable value to write |
| wr_width | input | 5 | Duty width to write (active slots per period) |
| irq | input | 1 | Interrupt request; ends gating |
| cpu_clk_en | output | 1 | Core clock enable |

## Verification
Every result is due one clock edge after the stimulus that causes it. A write or an interrupt sampled at edge k shows on `cpu_clk_en` after edge k. A slot change shows after edge k+n·SLOT_CYCLES, where k is the edge of the latest write. The bench keeps a reference model of the enable bit, the width and the number of edges since the write. It updates that model at the moment it drives each input, and it compares `cpu_clk_en` at every falling edge. Every cycle is therefore checked at the point where the output must already have settled, and no output value goes unchecked.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

   localparam int CBG_WIDTH_W = 5;

   typedef logic [CBG_WIDTH_W-1:0] duty_t;

   typedef struct packed {
      logic  en;
      duty_t width;
   } burst_cfg_t;

   typedef enum logic [1:0] {
      GATE_FREE  = 2'd0,
      GATE_BURST = 2'd1,
      GATE_DOZE  = 2'd2
   } gate_mode_e;

endpackage

// File: rtl/cbg_cfg_reg.sv
module cbg_cfg_reg
   import cbg_pkg::*;
#(
   parameter int RESET_WIDTH = 31
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_enable_bit,
   input  duty_t      wr_width,
   input  logic       irq,
   output burst_cfg_t cfg,
   output gate_mode_e mode
);

   burst_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.en    <= 1'b0;
         cfg_q.width <= duty_t'(RESET_WIDTH);
      end else begin
         if (wr_en) begin
            cfg_q.width <= wr_width;
         end
         if (irq) begin
            cfg_q.en <= 1'b0;
         end else if (wr_en) begin
            cfg_q.en <= wr_enable_bit;
         end
      end
   end

   always_comb begin
      if (!cfg_q.en) begin
         mode = GATE_FREE;
      end else if (cfg_q.width == '0) begin
         mode = GATE_DOZE;
      end else begin
         mode = GATE_BURST;
      end
   end

   assign cfg = cfg_q;

endmodule

// File: rtl/cbg_slot_timer.sv
module cbg_slot_timer #(
   parameter int SLOT_CYCLES = 268,
   parameter int NUM_SLOTS   = 31,
   localparam int CYC_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   output logic [CYC_W-1:0]  cyc_cnt,
   output logic [SLOT_W-1:0] slot_idx
);

   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

   logic slot_tick;

   generate
      if (SLOT_CYCLES > 1) begin : g_divided
         localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);
         logic [CYC_W-1:0] cyc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cyc_q <= '0;
            end else if (restart) begin
               cyc_q <= '0;
            end else if (run) begin
               if (cyc_q == CYC_LAST) begin
                  cyc_q <= '0;
               end else begin
                  cyc_q <= cyc_q + CYC_W'(1);
               end
            end
         end

         assign slot_tick = run && !restart && (cyc_q == CYC_LAST);
         assign cyc_cnt   = cyc_q;
      end else begin : g_single
         assign slot_tick = run && !restart;
         assign cyc_cnt   = '0;
      end
   endgenerate

   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (restart) begin
         slot_q <= '0;
      end else if (slot_tick) begin
         if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
         end else begin
            slot_q <= slot_q + SLOT_W'(1);
         end
      end
   end

   assign slot_idx = slot_q;

endmodule

// File: rtl/cbg_duty_gate.sv
module cbg_duty_gate
   import cbg_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input  gate_mode_e        mode,
   input  duty_t             width,
   input  logic [SLOT_W-1:0] slot_idx,
   output logic              cpu_clk_en
);

   localparam int CMP_W = (SLOT_W > CBG_WIDTH_W) ? SLOT_W : CBG_WIDTH_W;

   logic [CMP_W-1:0] slot_ext;
   logic [CMP_W-1:0] width_ext;
   logic             in_window;

   assign slot_ext  = CMP_W'(slot_idx);
   assign width_ext = CMP_W'(width);
   assign in_window = (slot_ext < width_ext);

   always_comb begin
      unique case (mode)
         GATE_FREE:  cpu_clk_en = 1'b1;
         GATE_BURST: cpu_clk_en = in_window;
         GATE_DOZE:  cpu_clk_en = 1'b0;
         default:    cpu_clk_en = 1'b1;
      endcase
   end

endmodule

// File: rtl/cpu_burst_gate.sv
module cpu_burst_gate
   import cbg_pkg::*;
#(
   parameter int SLOT_CYCLES = 268,
   parameter int NUM_SLOTS   = 31
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic                   wr_enable_bit,
   input  logic [CBG_WIDTH_W-1:0] wr_width,
   input  logic                   irq,
   output logic                   cpu_clk_en
);

   localparam int CYC_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   initial begin
      if (SLOT_CYCLES < 1) begin
         $fatal(1, "cpu_burst_gate: SLOT_CYCLES must be at least 1");
      end
      if (NUM_SLOTS < 1 || NUM_SLOTS > (2**CBG_WIDTH_W) - 1) begin
         $fatal(1, "cpu_burst_gate: NUM_SLOTS must fit the width field");
      end
   end

   burst_cfg_t        cfg;
   gate_mode_e        mode;
   logic              cfg_en;
   logic [CYC_W-1:0]  cyc_cnt;
   logic [SLOT_W-1:0] slot_idx;

   cbg_cfg_reg #(
      .RESET_WIDTH (NUM_SLOTS)
   ) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_enable_bit (wr_enable_bit),
      .wr_width      (wr_width),
      .irq           (irq),
      .cfg           (cfg),
      .mode          (mode)
   );

   assign cfg_en = cfg.en;

   cbg_slot_timer #(
      .SLOT_CYCLES (SLOT_CYCLES),
      .NUM_SLOTS   (NUM_SLOTS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (cfg_en),
      .restart  (wr_en),
      .cyc_cnt  (cyc_cnt),
      .slot_idx (slot_idx)
   );

   cbg_duty_gate #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_gate (
      .mode       (mode),
      .width      (cfg.width),
      .slot_idx   (slot_idx),
      .cpu_clk_en (cpu_clk_en)
   );

endmodule

// File: rtl/cbg_chk.sv
module cbg_chk #(
   parameter int SLOT_CYCLES = 268,
   parameter int NUM_SLOTS   = 31,
   localparam int CYC_W  = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_enable_bit,
   input logic [4:0]        wr_width,
   input logic              irq,
   input logic              cpu_clk_en,
   input logic              cfg_en,
   input logic [CYC_W-1:0]  cyc_cnt,
   input logic [SLOT_W-1:0] slot_idx
);

   // R3
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_idx <= SLOT_W'(NUM_SLOTS - 1)) && (cyc_cnt <= CYC_W'(SLOT_CYCLES - 1)));

   // R5
   doze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_enable_bit && !irq && wr_width == 5'd0) |=> !cpu_clk_en);

   // R6
   full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_width == 5'(NUM_SLOTS)) |=> cpu_clk_en);

   // R7
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> (cpu_clk_en && !cfg_en));

   // R8
   free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> cpu_clk_en);

   // R9
   period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (slot_idx == '0 && cyc_cnt == '0));

   // R10
   slot_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$past(irq) && cyc_cnt != '0) |-> $stable(cpu_clk_en));

   // R11
   irq_over_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && irq) |=> !cfg_en);

endmodule

bind cpu_burst_gate cbg_chk #(
   .SLOT_CYCLES (SLOT_CYCLES),
   .NUM_SLOTS   (NUM_SLOTS)
) u_cbg_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_enable_bit (wr_enable_bit),
   .wr_width      (wr_width),
   .irq           (irq),
   .cpu_clk_en    (cpu_clk_en),
   .cfg_en        (cfg_en),
   .cyc_cnt       (cyc_cnt),
   .slot_idx      (slot_idx)
);

// File: tb/tb_cpu_burst_gate.sv
`timescale 1ns/1ps
module tb_cpu_burst_gate;

   localparam int SC = 5;
   localparam int NS = 31;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_enable_bit = 1'b0;
   logic [4:0] wr_width = 5'd0;
   logic       irq = 1'b0;
   logic       cpu_clk_en;

   int checks = 0;
   int errors = 0;

   bit m_en = 1'b0;
   int m_w  = 31;
   int m_t  = 0;

   always #10 clk = ~clk;

   cpu_burst_gate #(.SLOT_CYCLES(SC), .NUM_SLOTS(NS)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_enable_bit (wr_enable_bit),
      .wr_width      (wr_width),
      .irq           (irq),
      .cpu_clk_en    (cpu_clk_en)
   );

   function automatic bit exp_out();
      if (!m_en) return 1'b1;
      return (((m_t / SC) % NS) < m_w);
   endfunction

   function automatic void model_step(bit we, bit eb, int w, bit ir);
      if (we) begin
         m_en = eb && !ir;
         m_w  = w;
         m_t  = 0;
      end else begin
         if (m_en) m_t++;
         if (ir) m_en = 1'b0;
      end
   endfunction

   task automatic check(string tag);
      bit e;
      e = exp_out();
      checks++;
      if (cpu_clk_en !== e) begin
         errors++;
         $display("FAIL %s: cpu_clk_en actual %0b expected %0b (t=%0d w=%0d en=%0b)",
                  tag, cpu_clk_en, e, m_t, m_w, m_en);
      end
   endtask

   // One stimulus cycle on the first step, then idle; every cycle is checked.
   task automatic run(bit we, bit eb, int w, bit ir, string tag, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(tag);
         wr_en         = (i == 0) ? we : 1'b0;
         wr_enable_bit = eb;
         wr_width      = 5'(w);
         irq           = (i == 0) ? ir : 1'b0;
         model_step(wr_en, wr_enable_bit, w, irq);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state: free running clock enable
      run(1'b0, 1'b0, 0, 1'b0, "R1", 4);
      // R2 write takes effect on the next edge
      run(1'b1, 1'b1, 3, 1'b0, "R2", 40);
      // R3 slot length and period repetition, two full periods
      run(1'b1, 1'b1, 1, 1'b0, "R3", SC * NS * 2 + 3);
      // R4 mid duty window
      run(1'b1, 1'b1, 12, 1'b0, "R4", SC * NS + 10);
      run(1'b1, 1'b1, 30, 1'b0, "R4", SC * NS + 10);
      // R5 doze
      run(1'b1, 1'b1, 0, 1'b0, "R5", 100);
      // R6 full width
      run(1'b1, 1'b1, 31, 1'b0, "R6", 60);
      // R7 interrupt during a low window
      run(1'b1, 1'b1, 2, 1'b0, "R7", 40);
      run(1'b0, 1'b1, 2, 1'b1, "R7", 60);
      // R9 restart of the period mid-window
      run(1'b1, 1'b1, 7, 1'b0, "R9", 23);
      run(1'b1, 1'b1, 7, 1'b0, "R9", 60);
      // R8 enable cleared by software with a small width
      run(1'b1, 1'b0, 3, 1'b0, "R8", 40);
      // R11 write and interrupt in the same cycle
      run(1'b1, 1'b1, 5, 1'b1, "R11", 30);
      run(1'b1, 1'b1, 0, 1'b1, "R11", 10);
      // R10 random mix of writes and interrupts
      for (int k = 0; k < 60; k++) begin
         bit we, eb, ir;
         int w, n;
         we = ($urandom_range(3, 0) != 0);
         eb = ($urandom_range(4, 0) != 0);
         w  = $urandom_range(31, 0);
         ir = ($urandom_range(7, 0) == 0);
         n  = $urandom_range(90, 1);
         run(we, eb, w, ir, "R10", n);
      end
      @(negedge clk);
      check("R10");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule